// File: doc/BRIEF.md
# Dual-Channel Compare Timer with PWM Outputs

This block is an 8-bit timer-counter that advances on a prescaled enable pulse and drives two waveform outputs, channel A and channel B. A 3-bit waveform selector picks how the counter moves: free-running, clear-on-compare, single-slope PWM or dual-slope (up/down) PWM. Each channel has its own 2-bit action field, compare value and pin-direction bit. The action field decides whether the channel takes over its pin and what a compare hit does to the pin level. That effect depends on the waveform mode and, in dual-slope mode, on the direction of counting.

A surrounding timer wrapper supplies the prescaled enable and the configuration. It uses the override and drive outputs to steer the pin multiplexer, and it feeds the one-cycle hit and wrap pulses to an interrupt block. State changes only on clock edges where `cnt_en` is high. All pulse outputs are registered and appear in the cycle after the enabling edge.

Top module: `tmr_cmp_pwm`

## Requirements
- R1: After a synchronous active-low reset, `count` is 0, both waveform levels are 0, the counter direction is up, the buffered compare values are 0 and the pulse outputs `match_a`, `match_b` and `ovf` are 0.
- R2: `wave_sel[1:0]` encodes the mode: 00 free-running, 10 clear-on-compare, 11 single-slope PWM, 01 dual-slope PWM. `wave_sel[2]` makes the effective channel-A compare value the TOP in the two PWM modes. In clear-on-compare mode TOP is always the channel-A compare value. Otherwise TOP is 0xFF. In modes 00 and 10 the counter increments on each tick and returns to 0 after 0xFF (mode 10 also returns to 0 after reaching TOP). `ovf` pulses after a tick taken at 0xFF. On cycles with `cnt_en` low, nothing changes and no pulse is raised.
- R3: In single-slope PWM the counter runs 0..TOP and then restarts at 0. `ovf` pulses after the tick taken at TOP.
- R4: In dual-slope PWM the counter counts up to TOP, turns and counts down to 0, then turns up again. `ovf` pulses after the tick on which it turns at 0.
- R5: An action field of 00 disconnects the channel in every mode: its override output is low and its waveform level is held.
- R6: A drive output is high exactly when the channel overrides its pin and the channel's direction bit is 1.
- R7: In modes 00 and 10, a compare hit applies the action field: 01 toggles the level, 10 clears it and 11 sets it.
- R8: In single-slope PWM, field 10 clears the level on a hit and sets it on the tick that returns the counter to 0. Field 11 sets it on a hit and clears it on that tick.
- R9: In either PWM mode, field 01 on channel A toggles the level on a hit, but only while `wave_sel[2]` is 1; otherwise it disconnects. Field 01 on channel B always disconnects in PWM modes.
- R10: In dual-slope PWM, field 10 clears the level on a hit when the counter moves up after that tick, and sets it when the counter moves down after that tick. Field 11 does the reverse.
- R11: In PWM modes, if the channel's compare value equals TOP and field bit 1 is set, the hit is ignored. Single-slope output then changes only at the return to 0. Dual-slope output is set (field 10) or cleared (field 11) on the tick taken at TOP.
- R12: In PWM modes the compare inputs are captured into the active compare values only on a tick taken at TOP. In modes 00 and 10 the compare inputs act at once.
- R13: `match_a` / `match_b` pulse for one cycle after a tick on which `count` equals that channel's active compare value, even when the hit's action is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Prescaled count enable (one tick) |
| wave_sel | input | 3 | Mode in [1:0], TOP-from-channel-A select in [2] |
| cmp_a_wr | input | 8 | Channel A compare value |
| cmp_b_wr | input | 8 | Channel B compare value |
| act_a | input | 2 | Channel A action field |
| act_b | input | 2 | Channel B action field |
| dir_a | input | 1 | Channel A pin direction (1 = output) |
| dir_b | input | 1 | Channel B pin direction (1 = output) |
| count | output | 8 | Counter value |
| wave_a | output | 1 | Channel A waveform level |
| wave_b | output | 1 | Channel B waveform level |
| ovr_a | output | 1 | Channel A takes over its pin |
| ovr_b | output | 1 | Channel B takes over its pin |
| drv_a | output | 1 | Channel A pin driver enable |
| drv_b | output | 1 | Channel B pin driver enable |
| match_a | output | 1 | Channel A compare-hit pulse |
| match_b | output | 1 | Channel B compare-hit pulse |
| ovf | output | 1 | Counter wrap / bottom-turn pulse |

## Verification
The bench targets compare values of 0x00 and TOP, including a channel B value equal to a channel-A-derived TOP. A design that failed to ignore the TOP hit would emit a one-count glitch each period instead of a steady level. In dual-slope mode, a design that took the hit direction from before the turn would leave a 0x00 compare stuck at the wrong level. Compare values are rewritten mid-run: a design that loaded them immediately in PWM modes would shorten or double-pulse the current period, or change the TOP of the running ramp too early. The reserved field 01 in PWM modes, with and without TOP select, catches a channel that keeps driving its pin when it should release it.

// File: rtl/tmr_pkg.sv
// Shared definitions for the compare timer.
// Assumes a 2-bit mode code; bit 0 set marks the PWM modes.
package tmr_pkg;

    typedef enum logic [1:0] {
        WM_FREE  = 2'b00,
        WM_DUAL  = 2'b01,
        WM_CLEAR = 2'b10,
        WM_SINGLE= 2'b11
    } wmode_e;

    // True for both PWM modes.
    function automatic logic is_pwm(input wmode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/tmr_counter.sv
// Counter core: steps the count on each tick according to the mode,
// tracks the dual-slope direction and raises the wrap pulse.
// Assumes TOP is stable within a PWM period (it comes from a buffered value).
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wmode_e       mode,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         up_next,
    output logic         at_top,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic         up_q;
    logic         ovf_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_n;
    logic         up_n;
    logic         wrap_n;

    // Next count, direction and wrap condition for the current mode.
    always_comb begin
        at_top = (cnt_q == top);
        cnt_n  = cnt_q + ONE;
        up_n   = 1'b1;
        wrap_n = 1'b0;
        unique case (mode)
            WM_FREE: begin
                wrap_n = (cnt_q == MAXV);
            end
            WM_CLEAR: begin
                cnt_n  = at_top ? ZERO : cnt_q + ONE;
                wrap_n = (cnt_q == MAXV);
            end
            WM_SINGLE: begin
                cnt_n  = at_top ? ZERO : cnt_q + ONE;
                wrap_n = at_top;
            end
            WM_DUAL: begin
                if (up_q) begin
                    if (at_top) begin
                        cnt_n = (top == ZERO) ? ZERO : cnt_q - ONE;
                        up_n  = 1'b0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                        up_n  = 1'b1;
                    end
                end else begin
                    if (cnt_q == ZERO) begin
                        cnt_n  = (top == ZERO) ? ZERO : ONE;
                        up_n   = 1'b1;
                        wrap_n = 1'b1;
                    end else begin
                        cnt_n = cnt_q - ONE;
                        up_n  = 1'b0;
                    end
                end
            end
            default: begin
                cnt_n = cnt_q;
            end
        endcase
    end

    // Counter, direction and wrap-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= tick && wrap_n;
            if (tick) begin
                cnt_q <= cnt_n;
                up_q  <= up_n;
            end
        end
    end

    assign cnt     = cnt_q;
    assign up_next = up_n;
    assign ovf     = ovf_q;

    // R3: single-slope restarts at zero after a tick at TOP.
    a_r3_single_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_SINGLE && at_top) |=> (cnt_q == ZERO));

    // R4: dual-slope turns upward after a tick at zero while falling.
    a_r4_bottom_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_DUAL && !up_q && cnt_q == ZERO) |=> up_q);

    // R2: no tick, no movement.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt_q == $past(cnt_q)));

    // R2: wrap pulse only follows a tick.
    a_r2_ovf_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> $past(tick));
endmodule

// File: rtl/tmr_cmp_buf.sv
// Compare-value holder: passes the written value straight through in
// non-PWM modes and captures it only at the TOP tick in PWM modes.
// Assumes load is already qualified with tick and TOP.
module tmr_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm,
    input  logic         load,
    input  logic [W-1:0] wr,
    output logic [W-1:0] eff
);
    logic [W-1:0] hold_q;

    // Shadow register: tracks input outside PWM, captures at TOP inside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!pwm || load) begin
            hold_q <= wr;
        end
    end

    assign eff = pwm ? hold_q : wr;

    // R12: in PWM modes the active value moves only on a load.
    a_r12_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load) |=> (hold_q == $past(hold_q)));
endmodule

// File: rtl/tmr_out_chan.sv
// One compare channel: detects hits, decides the pin takeover and
// updates the waveform level per mode, field and direction.
// Assumes cmp is the active (buffered) compare value and top is stable.
module tmr_out_chan
    import tmr_pkg::*;
#(
    parameter int W    = 8,
    parameter bit IS_A = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wmode_e       mode,
    input  logic         top_sel,
    input  logic [1:0]   field,
    input  logic         dir,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    input  logic         at_top,
    input  logic         up_next,
    output logic         wave,
    output logic         ovr,
    output logic         drv,
    output logic         match
);
    logic oc_q;
    logic oc_n;
    logic match_q;
    logic conn;
    logic hit;
    logic ignore;
    logic pwm;

    // Takeover decision and hit qualification.
    always_comb begin
        pwm    = is_pwm(mode);
        hit    = (cnt == cmp);
        ignore = pwm && field[1] && (cmp == top);
        conn   = (field != 2'b00) &&
                 !(pwm && field == 2'b01 && !(IS_A && top_sel));
    end

    // Next waveform level for this tick.
    always_comb begin
        oc_n = oc_q;
        if (conn && tick) begin
            unique case (mode)
                WM_FREE, WM_CLEAR: begin
                    if (hit) begin
                        unique case (field)
                            2'b01:   oc_n = ~oc_q;
                            2'b10:   oc_n = 1'b0;
                            2'b11:   oc_n = 1'b1;
                            default: oc_n = oc_q;
                        endcase
                    end
                end
                WM_SINGLE: begin
                    if (field == 2'b01) begin
                        if (hit) oc_n = ~oc_q;
                    end else begin
                        if (at_top)         oc_n = (field == 2'b10);
                        if (hit && !ignore) oc_n = (field == 2'b11);
                    end
                end
                WM_DUAL: begin
                    if (field == 2'b01) begin
                        if (hit) oc_n = ~oc_q;
                    end else if (ignore) begin
                        if (at_top) oc_n = (field == 2'b10);
                    end else if (hit) begin
                        oc_n = up_next ? (field == 2'b11) : (field == 2'b10);
                    end
                end
                default: oc_n = oc_q;
            endcase
        end
    end

    // Level and hit-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q    <= 1'b0;
            match_q <= 1'b0;
        end else begin
            oc_q    <= oc_n;
            match_q <= tick && hit;
        end
    end

    assign wave  = oc_q;
    assign ovr   = conn;
    assign drv   = conn && dir;
    assign match = match_q;

    // R5: a released channel keeps its level.
    a_r5_released_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conn |=> (oc_q == $past(oc_q)));

    // R13: a hit pulse only follows a tick.
    a_r13_hit_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> $past(tick));

    // R11: single-slope, field 10, compare at TOP gives a high level after the wrap.
    a_r11_top_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && conn && mode == WM_SINGLE && field == 2'b10 && cmp == top && at_top)
        |=> oc_q);
endmodule

// File: rtl/tmr_cmp_pwm.sv
// Top: counter core, two buffered compare values and two output channels.
// Assumes cnt_en is a single-cycle prescaled pulse and configuration is
// changed only while the wrapper accepts the resulting waveform.
module tmr_cmp_pwm
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [2:0]   wave_sel,
    input  logic [W-1:0] cmp_a_wr,
    input  logic [W-1:0] cmp_b_wr,
    input  logic [1:0]   act_a,
    input  logic [1:0]   act_b,
    input  logic         dir_a,
    input  logic         dir_b,
    output logic [W-1:0] count,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovr_a,
    output logic         ovr_b,
    output logic         drv_a,
    output logic         drv_b,
    output logic         match_a,
    output logic         match_b,
    output logic         ovf
);
    localparam int NCH = 2;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    wmode_e       mode;
    logic         pwm;
    logic         top_sel;
    logic [W-1:0] top;
    logic [W-1:0] cnt;
    logic         at_top;
    logic         up_next;
    logic         load;

    logic [W-1:0] wr_v   [NCH];
    logic [W-1:0] eff_v  [NCH];
    logic [1:0]   fld_v  [NCH];
    logic         dir_v  [NCH];
    logic         wave_v [NCH];
    logic         ovr_v  [NCH];
    logic         drv_v  [NCH];
    logic         hit_v  [NCH];

    // Mode decode, TOP selection and buffer load strobe.
    always_comb begin
        mode    = wmode_e'(wave_sel[1:0]);
        pwm     = is_pwm(mode);
        top_sel = wave_sel[2];
        top     = (mode == WM_CLEAR || (pwm && top_sel)) ? eff_v[0] : MAXV;
        load    = cnt_en && at_top && pwm;
    end

    assign wr_v[0]  = cmp_a_wr;
    assign wr_v[1]  = cmp_b_wr;
    assign fld_v[0] = act_a;
    assign fld_v[1] = act_b;
    assign dir_v[0] = dir_a;
    assign dir_v[1] = dir_b;

    tmr_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_en),
        .mode    (mode),
        .top     (top),
        .cnt     (cnt),
        .up_next (up_next),
        .at_top  (at_top),
        .ovf     (ovf)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_cmp_buf #(.W(W)) u_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .pwm   (pwm),
            .load  (load),
            .wr    (wr_v[i]),
            .eff   (eff_v[i])
        );

        tmr_out_chan #(.W(W), .IS_A(i == 0)) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (cnt_en),
            .mode    (mode),
            .top_sel (top_sel),
            .field   (fld_v[i]),
            .dir     (dir_v[i]),
            .cnt     (cnt),
            .cmp     (eff_v[i]),
            .top     (top),
            .at_top  (at_top),
            .up_next (up_next),
            .wave    (wave_v[i]),
            .ovr     (ovr_v[i]),
            .drv     (drv_v[i]),
            .match   (hit_v[i])
        );
    end

    assign count   = cnt;
    assign wave_a  = wave_v[0];
    assign wave_b  = wave_v[1];
    assign ovr_a   = ovr_v[0];
    assign ovr_b   = ovr_v[1];
    assign drv_a   = drv_v[0];
    assign drv_b   = drv_v[1];
    assign match_a = hit_v[0];
    assign match_b = hit_v[1];

    // R1: first cycle after reset shows a cleared counter and levels.
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (count == '0 && !wave_a && !wave_b && !ovf));
endmodule

// File: tb/sim_tmr_cmp_pwm.sv
`timescale 1ns/1ps
module sim_tmr_cmp_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [2:0] wave_sel = 3'd0;
    logic [7:0] cmp_a_wr = 8'd0;
    logic [7:0] cmp_b_wr = 8'd0;
    logic [1:0] act_a = 2'd0;
    logic [1:0] act_b = 2'd0;
    logic       dir_a = 1'b0;
    logic       dir_b = 1'b0;
    logic [7:0] count;
    logic wave_a, wave_b, ovr_a, ovr_b, drv_a, drv_b, match_a, match_b, ovf;

    tmr_cmp_pwm u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wave_sel(wave_sel),
        .cmp_a_wr(cmp_a_wr), .cmp_b_wr(cmp_b_wr), .act_a(act_a), .act_b(act_b),
        .dir_a(dir_a), .dir_b(dir_b), .count(count), .wave_a(wave_a),
        .wave_b(wave_b), .ovr_a(ovr_a), .ovr_b(ovr_b), .drv_a(drv_a),
        .drv_b(drv_b), .match_a(match_a), .match_b(match_b), .ovf(ovf)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit wrote  = 0;

    // Reference state
    int m_cnt;
    bit m_up;
    bit m_w  [2];
    int m_buf[2];
    bit m_mf [2];
    bit m_ovf;

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit next_level(input bit cur, input int f, input bit is_a,
                                      input int md, input bit tsel, input int c,
                                      input int cmp, input int top, input bit upn);
        bit pwm = (md == 1) || (md == 3);
        bit r;
        if (f == 0) return cur;
        if (pwm && f == 1) begin
            if (!(is_a && tsel)) return cur;
            return (c == cmp) ? !cur : cur;
        end
        if (!pwm) begin
            if (c != cmp) return cur;
            if (f == 1) return !cur;
            return f == 3;
        end
        if (md == 3) begin
            r = cur;
            if (c == top) r = (f == 2);
            if (c == cmp && cmp != top) r = (f == 3);
            return r;
        end
        if (cmp == top) return (c == top) ? (f == 2) : cur;
        if (c == cmp) return upn ? (f == 3) : (f == 2);
        return cur;
    endfunction

    function automatic bit linked(input int f, input bit is_a, input int md, input bit tsel);
        bit pwm = (md == 1) || (md == 3);
        if (f == 0) return 0;
        if (pwm && f == 1 && !(is_a && tsel)) return 0;
        return 1;
    endfunction

    // Advance reference by one clock edge using the inputs now applied.
    task automatic model_step();
        int md   = int'(wave_sel[1:0]);
        bit pwm  = wave_sel[0];
        bit tsel = wave_sel[2];
        int eff[2];
        int cin[2];
        int top, nc;
        bit nu, ov;
        cin[0] = int'(cmp_a_wr);
        cin[1] = int'(cmp_b_wr);
        eff[0] = pwm ? m_buf[0] : cin[0];
        eff[1] = pwm ? m_buf[1] : cin[1];
        top = (md == 2 || (pwm && tsel)) ? eff[0] : 255;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_ovf = 0;
            for (int k = 0; k < 2; k++) begin
                m_w[k] = 0; m_buf[k] = 0; m_mf[k] = 0;
            end
            return;
        end
        if (cnt_en) begin
            nu = 1; ov = 0;
            if (md == 0) begin
                nc = (m_cnt + 1) % 256; ov = (m_cnt == 255);
            end else if (md == 2) begin
                nc = (m_cnt == top) ? 0 : (m_cnt + 1) % 256; ov = (m_cnt == 255);
            end else if (md == 3) begin
                nc = (m_cnt == top) ? 0 : (m_cnt + 1) % 256; ov = (m_cnt == top);
            end else begin
                if (m_up) begin
                    if (m_cnt == top) begin nc = (top == 0) ? 0 : m_cnt - 1; nu = 0; end
                    else nc = m_cnt + 1;
                end else if (m_cnt == 0) begin
                    nc = (top == 0) ? 0 : 1; nu = 1; ov = 1;
                end else begin
                    nc = m_cnt - 1; nu = 0;
                end
            end
            for (int k = 0; k < 2; k++) begin
                int f = (k == 0) ? int'(act_a) : int'(act_b);
                m_w[k]  = next_level(m_w[k], f, k == 0, md, tsel, m_cnt, eff[k], top, nu);
                m_mf[k] = (m_cnt == eff[k]);
            end
            m_ovf = ov;
            if (pwm && m_cnt == top) begin
                m_buf[0] = cin[0]; m_buf[1] = cin[1];
            end
            m_cnt = nc;
            m_up  = nu;
        end else begin
            m_mf[0] = 0; m_mf[1] = 0; m_ovf = 0;
        end
        if (!pwm) begin
            m_buf[0] = cin[0]; m_buf[1] = cin[1];
        end
    endtask

    function automatic string level_tag(input int f, input int md);
        bit pwm = (md == 1) || (md == 3);
        int top = (md == 2 || (pwm && wave_sel[2])) ? (pwm ? m_buf[0] : int'(cmp_a_wr)) : 255;
        if (wrote && pwm) return "R12";
        if (pwm && f == 1) return "R9";
        if (pwm && f >= 2 && (m_buf[0] == top || m_buf[1] == top)) return "R11";
        if (md == 3) return "R8";
        if (md == 1) return "R10";
        return "R7";
    endfunction

    task automatic compare_all();
        int md = int'(wave_sel[1:0]);
        string ct = (md == 3) ? "R3" : (md == 1) ? "R4" : "R2";
        bit la = linked(int'(act_a), 1, md, wave_sel[2]);
        bit lb = linked(int'(act_b), 0, md, wave_sel[2]);
        chk(int'(count), m_cnt, ct, "count");
        chk(int'(ovf), int'(m_ovf), ct, "ovf");
        chk(int'(wave_a), int'(m_w[0]), level_tag(int'(act_a), md), "wave_a");
        chk(int'(wave_b), int'(m_w[1]), level_tag(int'(act_b), md), "wave_b");
        chk(int'(ovr_a), int'(la), (act_a == 2'b01) ? "R9" : "R5", "ovr_a");
        chk(int'(ovr_b), int'(lb), (act_b == 2'b01) ? "R9" : "R5", "ovr_b");
        chk(int'(drv_a), int'(la && dir_a), "R6", "drv_a");
        chk(int'(drv_b), int'(lb && dir_b), "R6", "drv_b");
        chk(int'(match_a), int'(m_mf[0]), "R13", "match_a");
        chk(int'(match_b), int'(m_mf[1]), "R13", "match_b");
    endtask

    task automatic run(input int md, input int fa, input int fb, input int ca,
                       input int cb, input bit db, input int ncyc);
        @(negedge clk);
        wave_sel = md[2:0];
        act_a = fa[1:0]; act_b = fb[1:0];
        cmp_a_wr = ca[7:0]; cmp_b_wr = cb[7:0];
        dir_a = 1'b1; dir_b = db;
        cnt_en = 1'b0;
        rst_n = 1'b0;
        wrote = 0;
        model_step();
        @(negedge clk);
        model_step();
        @(negedge clk);
        // R1: reset state
        chk(int'(count), 0, "R1", "reset count");
        chk(int'(wave_a) + int'(wave_b), 0, "R1", "reset levels");
        chk(int'(match_a) + int'(match_b) + int'(ovf), 0, "R1", "reset pulses");
        rst_n = 1'b1;
        cnt_en = 1'b1;
        model_step();
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            compare_all();
            if (i == ncyc / 2) begin
                cmp_a_wr = cmp_a_wr ^ 8'h18;
                cmp_b_wr = cmp_b_wr ^ 8'h20;
                wrote = 1;
            end
            cnt_en = ((i % 5) != 3);
            model_step();
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int modes[6] = '{0, 2, 3, 7, 1, 5};
        int cav[3]   = '{255, 128, 96};
        int cbv[3]   = '{0, 64, 96};
        int r = 0;
        for (int m = 0; m < 6; m++) begin
            for (int fa = 0; fa < 4; fa++) begin
                for (int c = 0; c < 3; c++) begin
                    run(modes[m], fa, (fa + 2) % 4, cav[c], cbv[c], r[0], 1300);
                    r++;
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule